// File: doc/BRIEF.md
# Oversampling Receive Resynchronizer

This block sits in front of a serial receiver's shift register and framing logic. It is clocked at sixteen times the bit rate and watches a single asynchronous serial line. It passes the line through a two-flop synchronizer and a three-sample debounce filter. It then finds and qualifies a start bit, and after that emits one data sample per bit period. Each sample is taken at mid-bit as the filtered level.

While receiving, the block keeps realigning its sixteen-state bit-phase counter to every qualified edge seen in the data. Because of this, bit timing follows the far end's clock rather than the local one. Long runs of data without start or stop bits can therefore be received as long as edges occur often enough.

A mode input selects a one-clock-per-bit mode instead of oversampling. In that mode, false-start checking is bypassed: the block waits for the first zero and then delivers the line level on every clock. An enable turns the receiver on or off, and a synchronous abort from the framing logic sends it back to idle after a character.

Top module: `async_rx_resync`

## Requirements
- R1: While reset is asserted and directly after it, bit_valid and start_det are low, and with the line held high nothing is produced.
- R2: A line level is accepted only after the synchronized input has differed from the filtered level on 3 consecutive clock edges. A low pulse lasting 2 clocks produces neither start_det nor bit_valid.
- R3: In 16x mode (async_en=1, x16_mode=1), start_det is a one-cycle pulse. If the line goes low and stays low, start_det is high in the cycle after the 13th rising edge counted from the first edge at which rx_in is low. This latency is 2 synchronizer edges, 3 filter edges and 8 qualification edges.
- R4: In 16x mode, a filtered rising edge on any of the 8 edges that follow the filtered falling edge rejects the start bit and returns the block to idle. A line low for 8 clocks is rejected; a line low for 9 clocks is accepted.
- R5: After start_det, and with no further line edges, bit_valid pulses for one cycle every 16 clocks, the first 16 clocks after start_det. bit_data carries the filtered line level.
- R6: A filtered edge accepted while the bit-phase counter is at 4 or above forces the counter to 0. The next bit_valid then appears 8 clocks after the start_det-relative position of that edge, carrying the new level.
- R7: A filtered edge that occurs while the bit-phase counter is at 0 to 3 does not move the sampling instant, but the new level is still the one sampled.
- R8: In x1 mode (async_en=1, x16_mode=0), no start qualification is done. The first synchronized zero raises start_det and bit_valid together, with bit_data=0. From then on, bit_valid is high every clock and bit_data is the synchronized line level.
- R9: With async_en low the block stays idle and produces no start_det or bit_valid, whatever the line does.
- R10: abort returns the block to idle at the next clock edge. No further bit_valid is produced until a new start bit has been qualified.
- R11: In 16x mode, start_det never coincides with bit_valid, and two bit_valid pulses are always at least 9 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16x the bit rate in 16x mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| async_en | input | 1 | Enables asynchronous reception; low holds the block idle |
| x16_mode | input | 1 | 1 selects 16x oversampling with start qualification, 0 selects one clock per bit |
| abort | input | 1 | Synchronous return to idle |
| bit_valid | output | 1 | One-cycle strobe: bit_data holds a received bit |
| bit_data | output | 1 | Sampled bit value |
| start_det | output | 1 | One-cycle pulse on an accepted start |

## Verification
The bound checker watches several properties on every cycle. It confirms that reset, a low enable and abort all silence the outputs, and that start_det is a single-cycle pulse. In 16x mode it also checks that start_det never overlaps a data strobe and that data strobes are never closer than the minimum spacing the phase counter allows. What only the directed scenarios can show is exact timing. That covers glitch rejection by the filter, the 8-versus-9-clock boundary of start qualification, and the exact cycle and value of samples after realignment. It also covers the ignored window at phases 0 to 3 and the cycle-by-cycle data path of x1 mode.

// File: rtl/async_rx_resync.sv
module async_rx_resync #(
  parameter int OSR         = 16,
  parameter int DEB_LEN     = 3,
  parameter int START_LEN   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic async_en,
  input  logic x16_mode,
  input  logic abort,
  output logic bit_valid,
  output logic bit_data,
  output logic start_det
);
  localparam int CW        = $clog2(OSR);
  localparam int DW        = $clog2(DEB_LEN + 1);
  localparam int SAMPLE_PT = OSR / 2;
  localparam int CHECK_PT  = OSR / 4;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_X1} state_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;
  logic [DW-1:0]          run_q;
  logic [CW-1:0]          cnt_q;
  state_t                 state_q;
  logic                   bv_q, bd_q, sd_q;

  wire din     = sync_q[SYNC_STAGES-1];
  wire differ  = din != lvl_q;
  wire vt      = differ && (run_q == DW'(DEB_LEN - 1));
  wire vt_rise = vt && din;
  wire vt_fall = vt && !din;
  wire [CW-1:0] cnt_nx = (cnt_q == CW'(OSR - 1)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      lvl_q  <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
      if (!differ) run_q <= '0;
      else if (vt) begin
        run_q <= '0;
        lvl_q <= din;
      end else run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bv_q    <= 1'b0;
      bd_q    <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      bv_q <= 1'b0;
      sd_q <= 1'b0;
      if (abort || !async_en) state_q <= S_IDLE;
      else begin
        case (state_q)
          S_IDLE: begin
            if (!x16_mode) begin
              if (!din) begin
                state_q <= S_X1;
                sd_q    <= 1'b1;
                bv_q    <= 1'b1;
                bd_q    <= 1'b0;
              end
            end else if (vt_fall) begin
              state_q <= S_START;
              cnt_q   <= '0;
            end
          end
          S_START: begin
            if (!x16_mode || vt_rise) state_q <= S_IDLE;
            else begin
              cnt_q <= cnt_nx;
              if (cnt_q == CW'(START_LEN - 1)) begin
                state_q <= S_DATA;
                sd_q    <= 1'b1;
              end
            end
          end
          S_DATA: begin
            if (!x16_mode) state_q <= S_IDLE;
            else if (vt && cnt_q >= CW'(CHECK_PT)) cnt_q <= '0;
            else begin
              cnt_q <= cnt_nx;
              if (cnt_q == CW'(SAMPLE_PT - 1)) begin
                bv_q <= 1'b1;
                bd_q <= lvl_q;
              end
            end
          end
          default: begin
            if (x16_mode) state_q <= S_IDLE;
            else begin
              bv_q <= 1'b1;
              bd_q <= din;
            end
          end
        endcase
      end
    end
  end

  assign bit_valid = bv_q;
  assign bit_data  = bd_q;
  assign start_det = sd_q;
endmodule

// File: rtl/async_rx_resync_chk.sv
module async_rx_resync_chk #(
  parameter int OSR = 16
) (
  input logic clk,
  input logic rst_n,
  input logic async_en,
  input logic x16_mode,
  input logic abort,
  input logic bit_valid,
  input logic start_det
);
  localparam int MIN_GAP = OSR / 2 + 1;

  logic [7:0] gap_q;
  logic       clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      clean_q <= 1'b0;
    end else if (bit_valid) begin
      gap_q   <= 8'd1;
      clean_q <= x16_mode && async_en && !abort;
    end else begin
      if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
      clean_q <= clean_q && x16_mode && async_en && !abort;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!bit_valid && !start_det));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !async_en |=> (!bit_valid && !start_det));

  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!bit_valid && !start_det));

  a_r11_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !start_det);

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && bit_valid) |-> !$past(x16_mode));

  a_r11_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && clean_q) |-> (gap_q >= 8'(MIN_GAP)));
endmodule

bind async_rx_resync async_rx_resync_chk #(.OSR(OSR)) u_chk (
  .clk(clk), .rst_n(rst_n), .async_en(async_en), .x16_mode(x16_mode),
  .abort(abort), .bit_valid(bit_valid), .start_det(start_det)
);

// File: tb/test_async_rx_resync.sv
module test_async_rx_resync;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic async_en = 1'b1;
  logic x16_mode = 1'b1;
  logic abort = 1'b0;
  logic bit_valid, bit_data, start_det;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  async_rx_resync i_async_rx_resync (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .async_en(async_en),
    .x16_mode(x16_mode), .abort(abort), .bit_valid(bit_valid),
    .bit_data(bit_data), .start_det(start_det)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    abort = 1'b1;
    step();
    abort = 1'b0;
    rx_in = 1'b1;
    repeat (12) step();
  endtask

  // Drives rx low from the current negedge for low_len clocks and compares
  // the outputs after every edge m (= k-1) with the expected events.
  task automatic observe(input string req, input int low_len, input int n,
                         input int sd_a, input int sd_b,
                         input int bv_a, input int bv_b,
                         input int d_a, input int d_b,
                         input int abort_at, input int refall_at);
    rx_in = 1'b0;
    for (int k = 1; k <= n; k++) begin
      int m;
      step();
      m = k - 1;
      chk({req, " start_det"}, int'(start_det), int'(m == sd_a || m == sd_b));
      chk({req, " bit_valid"}, int'(bit_valid), int'(m == bv_a || m == bv_b));
      if (m == bv_a) chk({req, " bit_data"}, int'(bit_data), d_a);
      if (m == bv_b) chk({req, " bit_data"}, int'(bit_data), d_b);
      if (k == low_len) rx_in = 1'b1;
      abort = (k == abort_at);
      if (k == refall_at) rx_in = 1'b0;
    end
    abort = 1'b0;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R1 in reset bit_valid", int'(bit_valid), 0);
      chk("R1 in reset start_det", int'(start_det), 0);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R1 after reset bit_valid", int'(bit_valid), 0);
      chk("R1 after reset start_det", int'(start_det), 0);
    end
  endtask

  task automatic t_glitch();
    observe("R2 glitch", 2, 30, -1, -1, -1, -1, 0, 0, -1, -1);
    settle();
  endtask

  task automatic t_false_start();
    observe("R4 low6", 6, 40, -1, -1, -1, -1, 0, 0, -1, -1);
    settle();
    observe("R4 low8", 8, 40, -1, -1, -1, -1, 0, 0, -1, -1);
    settle();
  endtask

  task automatic t_good_start();
    // R3/R4: low for 9 clocks is accepted; early rise realigns (R6)
    observe("R3 low9", 9, 40, 12, -1, 21, 37, 1, 1, -1, -1);
    settle();
  endtask

  task automatic t_free_run();
    observe("R5 free run", 60, 50, 12, -1, 28, 44, 0, 0, -1, -1);
    settle();
  endtask

  task automatic t_resync();
    observe("R6 resync", 12, 45, 12, -1, 24, 40, 1, 1, -1, -1);
    settle();
  endtask

  task automatic t_window();
    observe("R7 ignore window", 19, 50, 12, -1, 28, 44, 1, 1, -1, -1);
    settle();
  endtask

  task automatic t_abort();
    observe("R10 abort", 9, 46, 12, 37, -1, -1, 0, 0, 15, 25);
    settle();
  endtask

  task automatic t_x1();
    x16_mode = 1'b0;
    settle();
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R8 waits for zero bit_valid", int'(bit_valid), 0);
    end
    rx_in = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      int m;
      step();
      m = k - 1;
      chk("R8 x1 start_det", int'(start_det), int'(m == 2));
      chk("R8 x1 bit_valid", int'(bit_valid), int'(m >= 2));
      if (m >= 2) chk("R8 x1 bit_data", int'(bit_data), int'(m >= 5));
      if (k == 3) rx_in = 1'b1;
    end
    x16_mode = 1'b1;
    settle();
  endtask

  task automatic t_disabled();
    async_en = 1'b0;
    rx_in = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      step();
      chk("R9 disabled bit_valid", int'(bit_valid), 0);
      chk("R9 disabled start_det", int'(start_det), 0);
      if (k == 20) rx_in = 1'b1;
    end
    async_en = 1'b1;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    settle();
    t_glitch();
    t_false_start();
    t_good_start();
    t_free_run();
    t_resync();
    t_window();
    t_abort();
    t_x1();
    t_disabled();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule